// File: doc/BRIEF.md
# Single-Slot 16-bit Execution Unit with Status Flags

This block is the arithmetic and logic engine behind one instruction slot of a small statically scheduled compute element. Each cycle the slot's decoder may present an operation code, a function field, three 16-bit source operands, a shift amount and an immediate, qualified by an issue strobe. One clock edge later the unit presents a result (up to 32 bits wide) and a 4-bit status word that records what the latest flag-setting operation produced.

The operation set covers 16-bit unsigned add and subtract (optionally against a 9-bit or 15-bit zero-extended immediate), logical shifts and rotates at 16 and 32 bits, a fused bitwise function of three operands whose 8-entry truth table arrives in the immediate, and a single-bit lookup on the lowest bits of the three operands that writes a software-visible user flag. A two-way select chooses between two operands on any status bit, with optional inversion, so that branch and select decisions downstream can be driven from the status word.

Top module: `slot_exec_unit`

## Requirements
- R1: While `rst` is high on a clock edge, `result`, `done` and `status` become zero on that edge.
- R2: Opcode 0 adds: `result[15:0]` = (A + B) mod 65536, upper result bits zero; `status[2]` = carry out, `status[1]` = signed overflow, `status[0]` = result is zero, `status[3]` kept. B is `src_b` when `func[3]`=0; otherwise it is the immediate zero-extended, using `imm[8:0]` when `func[2]`=0 and all of `imm[14:0]` when `func[2]`=1.
- R3: Opcode 1 subtracts A − B (B chosen as in R2); `status[2]` is 1 exactly when no borrow occurs (A ≥ B), `status[1]` is signed overflow, `status[0]` zero, `status[3]` kept.
- R4: Opcodes 2, 3, 4, 5 are shift left, shift right, rotate left and rotate right of `src_a` at 16 bits by `shamt`; shifts by 16 or more give zero, rotates use `shamt` modulo 16.
- R5: Opcodes 6, 7, 8, 9 are the same four operations at 32 bits on the value {`src_c`, `src_a`} (`src_c` in the upper half); shifts by 32 or more give zero, rotates use `shamt` modulo 32.
- R6: Shift, rotate and fused-logic operations (opcodes 2 to 10) set `status[0]` when the whole result is zero, clear `status[2]` and `status[1]`, and keep `status[3]`.
- R7: Opcode 10 is fused logic: result bit i equals `imm[{src_c[i], src_b[i], src_a[i]}]` for every i in 0..15.
- R8: Opcode 11 is the single-bit lookup: the bit `imm[{src_c[0], src_b[0], src_a[0]}]` is written to `status[3]` and appears zero-extended on `result`; `status[2:0]` are kept.
- R9: Opcode 12 selects: `result` = `src_a` when `status[func[1:0]]` XOR `func[2]` is 1 (using the status before this operation), otherwise `src_b`; `status` is unchanged.
- R10: Opcode 13 moves `src_a` to `result`; opcodes 14 and 15 produce a zero result; none of the three changes `status`.
- R11: `done` is `issue` delayed by one cycle; in a cycle without `issue`, `result` and `status` hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue | input | 1 | Operation present this cycle |
| opcode | input | 4 | Operation code |
| func | input | 4 | Function field (immediate selection, select condition) |
| src_a | input | 16 | First operand |
| src_b | input | 16 | Second operand |
| src_c | input | 16 | Third operand, upper half of 32-bit shifts |
| shamt | input | 6 | Shift or rotate amount |
| imm | input | 15 | Immediate; low 8 bits are the truth table for opcodes 10 and 11 |
| result | output | 32 | Registered result |
| done | output | 1 | Result and status updated by an issued operation |
| status | output | 4 | {user flag, carry, overflow, zero} |

## Verification
The checker takes for granted that every input is at a known value whenever `issue` is high and that `rst` is applied before the first operation, so that the hold and flag-preservation properties compare against defined earlier state. The bench drives all inputs from known values at every falling edge, lowers `issue` between operations so that each result is followed by an idle cycle in which the hold behaviour is exercised, and orders its vectors so that the user flag is set and cleared by lookups before the select operations read it.

// File: rtl/slot_exec_pkg.sv
package slot_exec_pkg;

    // Operation codes carried in the top four bits of the instruction word
    typedef enum logic [3:0] {
        OP_ADD    = 4'd0,
        OP_SUB    = 4'd1,
        OP_SHL    = 4'd2,
        OP_SHR    = 4'd3,
        OP_ROL    = 4'd4,
        OP_ROR    = 4'd5,
        OP_SHLW   = 4'd6,
        OP_SHRW   = 4'd7,
        OP_ROLW   = 4'd8,
        OP_RORW   = 4'd9,
        OP_LOGIC3 = 4'd10,
        OP_LUT1   = 4'd11,
        OP_SEL    = 4'd12,
        OP_MOV    = 4'd13,
        OP_RSV0   = 4'd14,
        OP_RSV1   = 4'd15
    } op_e;

    // Status word, most significant field first so bit 3 is the user flag
    typedef struct packed {
        logic user;
        logic carry;
        logic ovf;
        logic zero;
    } flags_t;

    // Number of truth-table inputs for the fused logic and single-bit lookup
    localparam int LUT_IN = 3;

    function automatic logic is_narrow_shift(op_e op);
        return (op == OP_SHL) || (op == OP_SHR) || (op == OP_ROL) || (op == OP_ROR);
    endfunction

    function automatic logic is_wide_shift(op_e op);
        return (op == OP_SHLW) || (op == OP_SHRW) || (op == OP_ROLW) || (op == OP_RORW);
    endfunction

    function automatic logic is_left(op_e op);
        return (op == OP_SHL) || (op == OP_ROL) || (op == OP_SHLW) || (op == OP_ROLW);
    endfunction

    function automatic logic is_rotate(op_e op);
        return (op == OP_ROL) || (op == OP_ROR) || (op == OP_ROLW) || (op == OP_RORW);
    endfunction

endpackage

// File: rtl/slot_exec_arith.sv
module slot_exec_arith #(
    parameter int W = 16
) (
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    input  logic         subtract,
    output logic [W-1:0] sum,
    output logic         carry,
    output logic         ovf
);
    logic [W:0] wide;

    always_comb begin
        if (subtract) begin
            wide  = {1'b0, opa} - {1'b0, opb};
            // carry means no borrow
            carry = ~wide[W];
            ovf   = (opa[W-1] != opb[W-1]) && (wide[W-1] != opa[W-1]);
        end else begin
            wide  = {1'b0, opa} + {1'b0, opb};
            carry = wide[W];
            ovf   = (opa[W-1] == opb[W-1]) && (wide[W-1] != opa[W-1]);
        end
        sum = wide[W-1:0];
    end
endmodule

// File: rtl/slot_exec_shift.sv
module slot_exec_shift #(
    parameter int W     = 16,
    parameter int AMT_W = 6
) (
    input  logic [W-1:0]     val,
    input  logic [AMT_W-1:0] amt,
    input  logic             left,
    input  logic             rotate,
    output logic [W-1:0]     out
);
    localparam int RW = $clog2(W);

    logic [RW-1:0] rot;
    logic [W-1:0]  shl_v, shr_v, rol_v, ror_v;

    always_comb begin
        rot   = amt[RW-1:0];
        // an amount of W or more shifts every bit out
        shl_v = val << amt;
        shr_v = val >> amt;
        rol_v = (val << rot) | (val >> (W - int'(rot)));
        ror_v = (val >> rot) | (val << (W - int'(rot)));
        if (rotate) out = left ? rol_v : ror_v;
        else        out = left ? shl_v : shr_v;
    end
endmodule

// File: rtl/slot_exec_logic.sv
module slot_exec_logic #(
    parameter int W    = 16,
    parameter int TT_W = 8
) (
    input  logic [W-1:0]    opa,
    input  logic [W-1:0]    opb,
    input  logic [W-1:0]    opc,
    input  logic [TT_W-1:0] table_bits,
    output logic [W-1:0]    out
);
    // each result bit indexes the truth table with {c, b, a} of that position
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign out[i] = table_bits[{opc[i], opb[i], opa[i]}];
    end
endmodule

// File: rtl/slot_exec_unit.sv
module slot_exec_unit
    import slot_exec_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int SHAMT_W     = 6,
    parameter int IMM_W       = 15,
    parameter int IMM_SHORT_W = 9
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                issue,
    input  logic [3:0]          opcode,
    input  logic [3:0]          func,
    input  logic [DATA_W-1:0]   src_a,
    input  logic [DATA_W-1:0]   src_b,
    input  logic [DATA_W-1:0]   src_c,
    input  logic [SHAMT_W-1:0]  shamt,
    input  logic [IMM_W-1:0]    imm,
    output logic [2*DATA_W-1:0] result,
    output logic                done,
    output logic [3:0]          status
);
    localparam int WIDE_W = 2 * DATA_W;
    localparam int TT_W   = 1 << LUT_IN;

    op_e                op;
    logic [DATA_W-1:0]  opnd_b;
    logic [DATA_W-1:0]  arith_sum;
    logic               arith_c, arith_v;
    logic [DATA_W-1:0]  fused;
    logic [WIDE_W-1:0]  shift_src [2];
    logic [WIDE_W-1:0]  shift_res [2];
    logic               sel_cond;

    logic [WIDE_W-1:0]  res_q, res_d;
    flags_t             flg_q, flg_d;
    logic               done_q;

    assign op = op_e'(opcode);

    // second arithmetic operand: register or zero-extended immediate
    always_comb begin
        if (!func[3])     opnd_b = src_b;
        else if (func[2]) opnd_b = DATA_W'(imm);
        else              opnd_b = DATA_W'(imm[IMM_SHORT_W-1:0]);
    end

    slot_exec_arith #(.W(DATA_W)) u_arith (
        .opa      (src_a),
        .opb      (opnd_b),
        .subtract (op == OP_SUB),
        .sum      (arith_sum),
        .carry    (arith_c),
        .ovf      (arith_v)
    );

    slot_exec_logic #(.W(DATA_W), .TT_W(TT_W)) u_logic (
        .opa        (src_a),
        .opb        (src_b),
        .opc        (src_c),
        .table_bits (imm[TT_W-1:0]),
        .out        (fused)
    );

    assign shift_src[0] = WIDE_W'(src_a);
    assign shift_src[1] = {src_c, src_a};

    // narrow and wide shifters share the direction and rotate controls
    for (genvar g = 0; g < 2; g++) begin : g_shift
        localparam int GW = DATA_W << g;
        logic [GW-1:0] sh_out;
        slot_exec_shift #(.W(GW), .AMT_W(SHAMT_W)) u_shift (
            .val    (shift_src[g][GW-1:0]),
            .amt    (shamt),
            .left   (is_left(op)),
            .rotate (is_rotate(op)),
            .out    (sh_out)
        );
        assign shift_res[g] = WIDE_W'(sh_out);
    end

    // select condition reads the status held before this operation
    always_comb begin
        logic [3:0] flag_bits;
        flag_bits = flg_q;
        sel_cond  = flag_bits[func[1:0]] ^ func[2];
    end

    always_comb begin
        res_d = '0;
        flg_d = flg_q;
        if (op == OP_ADD || op == OP_SUB) begin
            res_d      = WIDE_W'(arith_sum);
            flg_d.carry = arith_c;
            flg_d.ovf   = arith_v;
            flg_d.zero  = (arith_sum == '0);
        end else if (is_narrow_shift(op) || is_wide_shift(op) || op == OP_LOGIC3) begin
            if (is_narrow_shift(op))    res_d = shift_res[0];
            else if (is_wide_shift(op)) res_d = shift_res[1];
            else                        res_d = WIDE_W'(fused);
            flg_d.carry = 1'b0;
            flg_d.ovf   = 1'b0;
            flg_d.zero  = (res_d == '0);
        end else begin
            case (op)
                OP_LUT1: begin
                    res_d      = WIDE_W'(fused[0]);
                    flg_d.user = fused[0];
                end
                OP_SEL:  res_d = WIDE_W'(sel_cond ? src_a : src_b);
                OP_MOV:  res_d = WIDE_W'(src_a);
                default: res_d = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q  <= '0;
            flg_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= issue;
            if (issue) begin
                res_q <= res_d;
                flg_q <= flg_d;
            end
        end
    end

    assign result = res_q;
    assign status = flg_q;
    assign done   = done_q;

endmodule

// File: rtl/slot_exec_unit_chk.sv
module slot_exec_unit_chk #(
    parameter int DATA_W  = 16,
    parameter int SHAMT_W = 6,
    parameter int IMM_W   = 15
) (
    input logic                clk,
    input logic                rst,
    input logic                issue,
    input logic [3:0]          opcode,
    input logic [3:0]          func,
    input logic [DATA_W-1:0]   src_a,
    input logic [DATA_W-1:0]   src_b,
    input logic [DATA_W-1:0]   src_c,
    input logic [SHAMT_W-1:0]  shamt,
    input logic [IMM_W-1:0]    imm,
    input logic [2*DATA_W-1:0] result,
    input logic                done,
    input logic [3:0]          status
);
    assert_hold_when_idle_R11: assert property (@(posedge clk) disable iff (rst)
        !issue |=> ($stable(result) && $stable(status)));

    assert_done_after_issue_R11: assert property (@(posedge clk) disable iff (rst)
        issue |=> done);

    assert_no_done_when_idle_R11: assert property (@(posedge clk) disable iff (rst)
        !issue |=> !done);

    assert_status_kept_R9: assert property (@(posedge clk) disable iff (rst)
        (issue && opcode >= 4'd12) |=> $stable(status));

    assert_move_passes_a_R10: assert property (@(posedge clk) disable iff (rst)
        (issue && opcode == 4'd13) |=> (result == (2*DATA_W)'($past(src_a))));

    assert_shift_flags_R6: assert property (@(posedge clk) disable iff (rst)
        (issue && opcode >= 4'd2 && opcode <= 4'd10) |=>
        (status[2:1] == 2'b00 && status[3] == $past(status[3])));

    assert_lookup_keeps_flags_R8: assert property (@(posedge clk) disable iff (rst)
        (issue && opcode == 4'd11) |=> (status[2:0] == $past(status[2:0])));

    assert_sub_equal_R3: assert property (@(posedge clk) disable iff (rst)
        (issue && opcode == 4'd1 && !func[3] && src_a == src_b) |=> (status[2] && status[0]));

    assert_shift_out_R4: assert property (@(posedge clk) disable iff (rst)
        (issue && opcode == 4'd2 && int'(shamt) >= DATA_W) |=> (result == '0));

endmodule

bind slot_exec_unit slot_exec_unit_chk #(
    .DATA_W  (DATA_W),
    .SHAMT_W (SHAMT_W),
    .IMM_W   (IMM_W)
) u_chk (.*);

// File: tb/slot_exec_unit_bench.sv
module slot_exec_unit_bench;

    typedef struct packed {
        logic [7:0]  req;
        logic [3:0]  op;
        logic [3:0]  fn;
        logic [15:0] a;
        logic [15:0] b;
        logic [15:0] c;
        logic [5:0]  amt;
        logic [14:0] imm;
        logic [31:0] res;
        logic [3:0]  psr;
    } vec_t;

    localparam int NV = 31;

    // applied in order; expected status follows from the previous entries
    localparam vec_t VEC [NV] = '{
        '{8'd2,  4'h0, 4'h0, 16'h0001, 16'h0002, 16'h0000, 6'd0,  15'h0000, 32'h00000003, 4'b0000}, // R2
        '{8'd2,  4'h0, 4'h0, 16'hFFFF, 16'h0001, 16'h0000, 6'd0,  15'h0000, 32'h00000000, 4'b0101}, // R2 carry
        '{8'd2,  4'h0, 4'h0, 16'h7FFF, 16'h0001, 16'h0000, 6'd0,  15'h0000, 32'h00008000, 4'b0010}, // R2 ovf
        '{8'd2,  4'h0, 4'h8, 16'h0010, 16'hFFFF, 16'h0000, 6'd0,  15'h7FFF, 32'h0000020F, 4'b0000}, // R2 short imm
        '{8'd2,  4'h0, 4'hC, 16'h0001, 16'hFFFF, 16'h0000, 6'd0,  15'h7FFF, 32'h00008000, 4'b0010}, // R2 long imm
        '{8'd3,  4'h1, 4'h0, 16'h0005, 16'h0003, 16'h0000, 6'd0,  15'h0000, 32'h00000002, 4'b0100}, // R3
        '{8'd3,  4'h1, 4'h0, 16'h0003, 16'h0005, 16'h0000, 6'd0,  15'h0000, 32'h0000FFFE, 4'b0000}, // R3 borrow
        '{8'd3,  4'h1, 4'h0, 16'h8000, 16'h0001, 16'h0000, 6'd0,  15'h0000, 32'h00007FFF, 4'b0110}, // R3 ovf
        '{8'd3,  4'h1, 4'h0, 16'h1234, 16'h1234, 16'h0000, 6'd0,  15'h0000, 32'h00000000, 4'b0101}, // R3 equal
        '{8'd8,  4'hB, 4'h0, 16'h0001, 16'h0001, 16'h0001, 6'd0,  15'h0080, 32'h00000001, 4'b1101}, // R8 set
        '{8'd4,  4'h2, 4'h0, 16'h8001, 16'h0000, 16'h0000, 6'd1,  15'h0000, 32'h00000002, 4'b1000}, // R4 R6
        '{8'd4,  4'h2, 4'h0, 16'hFFFF, 16'h0000, 16'h0000, 6'd16, 15'h0000, 32'h00000000, 4'b1001}, // R4 full
        '{8'd4,  4'h3, 4'h0, 16'h8000, 16'h0000, 16'h0000, 6'd15, 15'h0000, 32'h00000001, 4'b1000}, // R4
        '{8'd4,  4'h4, 4'h0, 16'h8001, 16'h0000, 16'h0000, 6'd17, 15'h0000, 32'h00000003, 4'b1000}, // R4 wrap
        '{8'd4,  4'h5, 4'h0, 16'h0001, 16'h0000, 16'h0000, 6'd4,  15'h0000, 32'h00001000, 4'b1000}, // R4
        '{8'd5,  4'h6, 4'h0, 16'h8000, 16'h0000, 16'h0000, 6'd1,  15'h0000, 32'h00010000, 4'b1000}, // R5
        '{8'd5,  4'h7, 4'h0, 16'h0000, 16'h0000, 16'h1234, 6'd16, 15'h0000, 32'h00001234, 4'b1000}, // R5
        '{8'd5,  4'h7, 4'h0, 16'hFFFF, 16'h0000, 16'hFFFF, 6'd32, 15'h0000, 32'h00000000, 4'b1001}, // R5 full
        '{8'd5,  4'h8, 4'h0, 16'h0001, 16'h0000, 16'h8000, 6'd4,  15'h0000, 32'h00000018, 4'b1000}, // R5
        '{8'd5,  4'h9, 4'h0, 16'h0001, 16'h0000, 16'h0000, 6'd33, 15'h0000, 32'h80000000, 4'b1000}, // R5 wrap
        '{8'd7,  4'hA, 4'h0, 16'h00FF, 16'h0F0F, 16'h3333, 6'd0,  15'h00E8, 32'h0000033F, 4'b1000}, // R7 majority
        '{8'd7,  4'hA, 4'h0, 16'hFFFF, 16'hFFFF, 16'hFFFF, 6'd0,  15'h0096, 32'h0000FFFF, 4'b1000}, // R7 parity
        '{8'd6,  4'hA, 4'h0, 16'h1357, 16'h2468, 16'h9999, 6'd0,  15'h0000, 32'h00000000, 4'b1001}, // R6 zero
        '{8'd8,  4'hB, 4'h0, 16'h0001, 16'h0001, 16'h0001, 6'd0,  15'h0001, 32'h00000000, 4'b0001}, // R8 clear
        '{8'd9,  4'hC, 4'h0, 16'hAAAA, 16'h5555, 16'h0000, 6'd0,  15'h0000, 32'h0000AAAA, 4'b0001}, // R9 zero
        '{8'd9,  4'hC, 4'h4, 16'hAAAA, 16'h5555, 16'h0000, 6'd0,  15'h0000, 32'h00005555, 4'b0001}, // R9 invert
        '{8'd9,  4'hC, 4'h1, 16'hAAAA, 16'h5555, 16'h0000, 6'd0,  15'h0000, 32'h00005555, 4'b0001}, // R9 ovf
        '{8'd10, 4'hD, 4'h0, 16'hBEEF, 16'h0000, 16'h0000, 6'd0,  15'h0000, 32'h0000BEEF, 4'b0001}, // R10 move
        '{8'd10, 4'hE, 4'h0, 16'h1111, 16'h2222, 16'h3333, 6'd0,  15'h0000, 32'h00000000, 4'b0001}, // R10 spare
        '{8'd8,  4'hB, 4'h0, 16'h0000, 16'h0001, 16'h0000, 6'd0,  15'h0004, 32'h00000001, 4'b1001}, // R8 index 2
        '{8'd9,  4'hC, 4'h3, 16'h1234, 16'h4321, 16'h0000, 6'd0,  15'h0000, 32'h00001234, 4'b1001}  // R9 user flag
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        issue;
    logic [3:0]  opcode, func;
    logic [15:0] src_a, src_b, src_c;
    logic [5:0]  shamt;
    logic [14:0] imm;
    logic [31:0] result;
    logic        done;
    logic [3:0]  status;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    slot_exec_unit u_slot_exec_unit (
        .clk    (clk),
        .rst    (rst),
        .issue  (issue),
        .opcode (opcode),
        .func   (func),
        .src_a  (src_a),
        .src_b  (src_b),
        .src_c  (src_c),
        .shamt  (shamt),
        .imm    (imm),
        .result (result),
        .done   (done),
        .status (status)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        summary();
    end

    initial begin
        rst = 1'b1; issue = 1'b0; opcode = '0; func = '0;
        src_a = '0; src_b = '0; src_c = '0; shamt = '0; imm = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 result", result, 32'h0);
        check("R1 status", 32'(status), 32'h0);
        check("R1 done", 32'(done), 32'h0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            opcode = VEC[i].op; func = VEC[i].fn;
            src_a = VEC[i].a; src_b = VEC[i].b; src_c = VEC[i].c;
            shamt = VEC[i].amt; imm = VEC[i].imm;
            issue = 1'b1;
            @(negedge clk);
            issue = 1'b0;
            check($sformatf("R%0d result vec%0d", VEC[i].req, i), result, VEC[i].res);
            check($sformatf("R%0d status vec%0d", VEC[i].req, i), 32'(status), 32'(VEC[i].psr));
            check($sformatf("R11 done vec%0d", i), 32'(done), 32'h1);
        end

        // R11: idle cycles with changing inputs leave outputs alone
        opcode = 4'h0; func = 4'h0; src_a = 16'hFFFF; src_b = 16'hFFFF;
        repeat (3) @(negedge clk);
        check("R11 idle result", result, 32'h00001234);
        check("R11 idle status", 32'(status), 32'h9);
        check("R11 idle done", 32'(done), 32'h0);

        // R1: reset in the middle of operation
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 mid result", result, 32'h0);
        check("R1 mid status", 32'(status), 32'h0);
        check("R1 mid done", 32'(done), 32'h0);

        summary();
    end

endmodule